// File: doc/BRIEF.md
# Sync-Aligned Video Pixel Sampler

The block runs on an oversampling clock that is a small integer multiple (3 to 6) of the pixel clock of an incoming raster line. From that clock it produces one sample strobe per pixel period. Each rising horizontal sync edge restarts the pixel position counter. The same edge reloads a sub-pixel phase divider from a programmable offset, so the sampling point can be moved in steps of one oversampling cycle.

All horizontal quantities are counted in pixels from the sync reference, as in modeline-style timing. An active flag is raised once the pixel index reaches a programmed start position and held for a programmed width. At each sync the pixel count of the line that just ended is latched and compared with a programmed total. An external processor writes the timing inputs. That processor is expected to sweep the phase and the ratio while it watches the line length, the mismatch flag and the captured pixels.

Top module: `vps_pixel_sampler`

## Requirements
- R1: `hsync_i` passes through a two-flop synchronizer. Its rising edge is detected in the cycle after the second flop goes high. The divider and the pixel counter are reloaded at the third clock edge after `hsync_i` is first sampled high. After that edge `pix_x_o` reads 0. No strobe is issued in the detection cycle.
- R2: The oversample ratio is `ratio_i` clamped to the range 3..6: values below 3 act as 3 and values above 6 act as 6. The ratio is captured only at a sync edge. Before the first sync it is 3.
- R3: At the sync edge the phase divider is loaded with `phase_i`, clamped to ratio-1. The first strobe of the line therefore comes ratio-1-phase cycles after the reload edge. A phase of ratio-1 puts the strobe in the very first cycle.
- R4: Between syncs `sample_o` is high for exactly one cycle in every ratio cycles. During a strobe, `pix_x_o` holds the index of the pixel being sampled, and that index is 0 for the first strobe of a line. `pix_x_o` increments by one after each strobe and holds between strobes. It saturates at its maximum value.
- R5: `active_o` is high exactly while `act_start_i <= pix_x_o < act_start_i + act_width_i`. The sum is taken with one extra bit, so it cannot wrap.
- R6: Once the pixel index has reached start + width, `active_o` stays low until the next sync.
- R7: At each sync edge `line_len_o` takes the value the pixel counter held when the sync was detected. That value is the number of strobes in the line just ended.
- R8: At each sync edge `len_err_o` is set to 1 if the latched line length differs from `line_total_i`, and to 0 otherwise. At the first sync after reset it is 0.
- R9: During and right after reset, `pix_x_o`, `line_len_o`, `len_err_o` and `active_o` are all 0, provided `act_width_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, asynchronous, active high |
| ratio_i | input | PH_W | Oversample ratio (clamped 3..6) |
| phase_i | input | PH_W | Sub-pixel phase offset loaded at sync |
| act_start_i | input | X_W | Pixels from sync to first active pixel |
| act_width_i | input | X_W | Number of active pixels |
| line_total_i | input | X_W | Expected pixels per line |
| sample_o | output | 1 | Pixel sample strobe |
| pix_x_o | output | X_W | Pixel index within the line |
| active_o | output | 1 | Active-region flag |
| line_len_o | output | X_W | Pixel count of the last completed line |
| len_err_o | output | 1 | Last line length differed from expected total |

## Verification
The bench uses the default parameters, PH_W = 3 and X_W = 12. With those widths every ratio and phase value the register fields can hold is reachable, including the out-of-range ratios 0..2 and 7 and phase values at or above the ratio, so both clamps are exercised. Lines are tens of pixels long, which covers active windows that start at 0, windows that end exactly at the line end and windows that overrun it, as well as lines whose lengths match and miss the programmed total. The 12-bit counter never saturates in those lines, so the saturation rule is covered only by its assertion.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam int unsigned RATIO_MIN = 3;
  localparam int unsigned RATIO_MAX = 6;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/vps_sync_edge.sv
module vps_sync_edge #(
  parameter int unsigned STAGES = vps_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], async_i};
  end

  // last synchronizer flop high, history flop still low
  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/vps_phase_div.sv
module vps_phase_div #(
  parameter int unsigned PH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  input  logic [PH_W-1:0] ratio_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            wrap_o
);
  import vps_pkg::*;
  localparam logic [PH_W-1:0] RMIN = PH_W'(RATIO_MIN);
  localparam logic [PH_W-1:0] RMAX = PH_W'(RATIO_MAX);

  logic [PH_W-1:0] ratio_n, phase_n, r_q, ph_q, last_q;

  always_comb begin
    if (ratio_i < RMIN)      ratio_n = RMIN;
    else if (ratio_i > RMAX) ratio_n = RMAX;
    else                     ratio_n = ratio_i;
    phase_n = (phase_i >= ratio_n) ? ratio_n - 1'b1 : phase_i;
  end

  assign last_q = r_q - 1'b1;
  assign wrap_o = ~sync_i & (ph_q >= last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q  <= RMIN;
      ph_q <= '0;
    end else if (sync_i) begin
      r_q  <= ratio_n;
      ph_q <= phase_n;
    end else if (ph_q >= last_q) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/vps_line_timer.sv
module vps_line_timer #(
  parameter int unsigned X_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_i,
  input  logic           wrap_i,
  input  logic [X_W-1:0] act_start_i,
  input  logic [X_W-1:0] act_width_i,
  input  logic [X_W-1:0] line_total_i,
  output logic [X_W-1:0] pix_x_o,
  output logic           active_o,
  output logic [X_W-1:0] line_len_o,
  output logic           len_err_o
);
  localparam logic [X_W-1:0] X_MAX = '1;

  logic [X_W-1:0] x_q, len_q;
  logic           err_q, armed_q;
  logic [X_W:0]   act_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      len_q   <= '0;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (sync_i) begin
      x_q     <= '0;
      len_q   <= x_q;
      err_q   <= armed_q & (x_q != line_total_i);
      armed_q <= 1'b1;
    end else if (wrap_i && x_q != X_MAX) begin
      x_q <= x_q + 1'b1;
    end
  end

  assign act_end    = {1'b0, act_start_i} + {1'b0, act_width_i};
  assign active_o   = (x_q >= act_start_i) && ({1'b0, x_q} < act_end);
  assign pix_x_o    = x_q;
  assign line_len_o = len_q;
  assign len_err_o  = err_q;
endmodule

// File: rtl/vps_pixel_sampler.sv
module vps_pixel_sampler #(
  parameter int unsigned PH_W = 3,
  parameter int unsigned X_W  = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hsync_i,
  input  logic [PH_W-1:0] ratio_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic [X_W-1:0]  act_start_i,
  input  logic [X_W-1:0]  act_width_i,
  input  logic [X_W-1:0]  line_total_i,
  output logic            sample_o,
  output logic [X_W-1:0]  pix_x_o,
  output logic            active_o,
  output logic [X_W-1:0]  line_len_o,
  output logic            len_err_o
);
  logic sync_pulse;
  logic wrap;

  vps_sync_edge #(.STAGES(vps_pkg::SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (hsync_i),
    .rise_o  (sync_pulse)
  );

  vps_phase_div #(.PH_W(PH_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_pulse),
    .ratio_i (ratio_i),
    .phase_i (phase_i),
    .wrap_o  (wrap)
  );

  vps_line_timer #(.X_W(X_W)) i_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (sync_pulse),
    .wrap_i       (wrap),
    .act_start_i  (act_start_i),
    .act_width_i  (act_width_i),
    .line_total_i (line_total_i),
    .pix_x_o      (pix_x_o),
    .active_o     (active_o),
    .line_len_o   (line_len_o),
    .len_err_o    (len_err_o)
  );

  assign sample_o = wrap;
endmodule

// File: rtl/vps_pixel_sampler_chk.sv
module vps_pixel_sampler_chk #(
  parameter int unsigned X_W = 12
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sync_i,
  input logic           sample_i,
  input logic [X_W-1:0] pix_x_i,
  input logic           active_i,
  input logic [X_W-1:0] act_start_i,
  input logic [X_W-1:0] line_len_i,
  input logic           len_err_i
);
  localparam logic [X_W-1:0] X_MAX = '1;

  assert_sync_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> pix_x_i == '0);

  assert_strobe_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> !sample_i);

  assert_pix_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> (pix_x_i == $past(pix_x_i) + 1'b1) || ($past(pix_x_i) == X_MAX));

  assert_pix_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !sync_i) |=> $stable(pix_x_i));

  assert_active_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> pix_x_i >= act_start_i);

  assert_len_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> line_len_i == $past(pix_x_i));

  assert_err_at_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(len_err_i));
endmodule

bind vps_pixel_sampler vps_pixel_sampler_chk #(.X_W(X_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_pulse),
  .sample_i    (sample_o),
  .pix_x_i     (pix_x_o),
  .active_i    (active_o),
  .act_start_i (act_start_i),
  .line_len_i  (line_len_o),
  .len_err_i   (len_err_o)
);

// File: tb/test_vps_pixel_sampler.sv
module test_vps_pixel_sampler;
  localparam int PH_W = 3;
  localparam int X_W  = 12;
  localparam int NLINES = 40;
  localparam int HS_W = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            hsync = 1'b0;
  logic [PH_W-1:0] ratio = '0, phase = '0;
  logic [X_W-1:0]  act_start = '0, act_width = '0, line_total = '0;
  logic            sample_o, active_o, len_err_o;
  logic [X_W-1:0]  pix_x_o, line_len_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  vps_pixel_sampler #(.PH_W(PH_W), .X_W(X_W)) i_vps_pixel_sampler (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hsync),
    .ratio_i(ratio), .phase_i(phase), .act_start_i(act_start),
    .act_width_i(act_width), .line_total_i(line_total),
    .sample_o(sample_o), .pix_x_o(pix_x_o), .active_o(active_o),
    .line_len_o(line_len_o), .len_err_o(len_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int eff_ratio(input int r);
    return (r < 3) ? 3 : (r > 6) ? 6 : r;
  endfunction

  function automatic int eff_phase(input int p, input int r);
    return (p >= r) ? r - 1 : p;
  endfunction

  // pixel count at offset joff after the reload edge, first strobe at offset d
  function automatic int xf(input int joff, input int d, input int r);
    return (joff <= d) ? 0 : ((joff - 1 - d) / r) + 1;
  endfunction

  function automatic bit strobe_at(input int joff, input int d, input int r);
    return (joff >= d) && (((joff - d) % r) == 0);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev_len, prev_d, prev_r, prev_T;
    bit have_prev;
    void'($urandom(32'd20240611));
    have_prev = 1'b0;
    prev_len = 0; prev_d = 0; prev_r = 3; prev_T = 0;

    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 pix_x", int'(pix_x_o), 0);
    chk("R9 line_len", int'(line_len_o), 0);
    chk("R9 len_err", int'(len_err_o), 0);
    chk("R9 active", int'(active_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    for (int li = 0; li <= NLINES; li++) begin
      int r_set, p_set, r, p, d, npix, T, st, wd, exp_err;
      bit clamp_line;
      clamp_line = 1'b0;
      case (li)
        1: begin r_set = 7; p_set = 7; clamp_line = 1'b1; end  // R2 upper clamp, R3 phase clamp
        2: begin r_set = 2; p_set = 0; clamp_line = 1'b1; end  // R2 lower clamp
        3: begin r_set = 5; p_set = 4; end                     // R3 phase = ratio-1
        default: begin r_set = 3 + int'($urandom_range(0, 3)); p_set = int'($urandom_range(0, 7)); end
      endcase
      r = eff_ratio(r_set);
      p = eff_phase(p_set, r);
      d = r - 1 - p;
      npix = 20 + int'($urandom_range(0, 40));
      T = npix * r + int'($urandom_range(0, r - 1));
      case (li)
        3: begin st = 0; wd = npix + 10; end           // R6 window overruns line
        4: begin st = 5; wd = 0; end                    // R5 empty window
        5: begin st = 0; wd = xf(T - 3, d, r); end      // R6 window ends at line end
        default: begin st = int'($urandom_range(0, npix)); wd = int'($urandom_range(0, npix)); end
      endcase
      // expected total for the line that ends at this sync
      exp_err = 0;
      if (have_prev && ($urandom_range(0, 1) == 1)) begin
        line_total = X_W'(prev_len + 1 + int'($urandom_range(0, 2)));
        exp_err = 1;
      end else begin
        line_total = X_W'(prev_len);
      end
      ratio = PH_W'(r_set);
      phase = PH_W'(p_set);
      act_start = X_W'(st);
      act_width = X_W'(wd);
      hsync = 1'b1;

      for (int j = 1; j <= T; j++) begin
        @(posedge clk);
        @(negedge clk);
        if (j == HS_W) hsync = 1'b0;
        if (j >= 3) begin
          int joff, x, a;
          joff = j - 3;
          x = xf(joff, d, r);
          a = (x >= st) && (x < st + wd);
          if (j == 3) chk("R1 pix_x after reload", int'(pix_x_o), 0);
          else        chk("R4 pix_x", int'(pix_x_o), x);
          if (joff < r)        chk("R3 first strobe", int'(sample_o), int'(strobe_at(joff, d, r)));
          else if (clamp_line) chk("R2 strobe spacing", int'(sample_o), int'(strobe_at(joff, d, r)));
          else                 chk("R4 strobe", int'(sample_o), int'(strobe_at(joff, d, r)));
          if (x < st + wd) chk("R5 active", int'(active_o), a);
          else             chk("R6 active after window", int'(active_o), 0);
          if (j == 3) begin
            if (have_prev) begin
              chk("R7 line_len", int'(line_len_o), prev_len);
              chk("R8 len_err", int'(len_err_o), exp_err);
            end else begin
              chk("R8 len_err first sync", int'(len_err_o), 0);
            end
          end
        end
      end
      prev_len = xf(T - 1, d, r);
      prev_d = d; prev_r = r; prev_T = T;
      have_prev = 1'b1;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule